// File: doc/BRIEF.md
# Boot Flash Region Swap and Write Guard

This block sits between a local-bus host and a 128 MB parallel NOR boot flash. The flash is 32 bits wide, built from two 16-bit devices. The block keeps a one-byte control/status register and reads two board switches. One switch forces write protection. The other chooses which of two 1 MB boot images is presented at the top of the flash address space.

The two boot images occupy the highest 2 MB of the space. Image A is the uppermost megabyte and image B is the megabyte just below it. When the boot-select switch is on and the register's override bit is clear, the block swaps those two megabytes by inverting address bit 20. Image B then answers at the highest addresses. Every other address passes through unchanged.

Flash write strobes are suppressed while protection is active. A suppressed write still completes on the host side, so software sees a normal cycle. Both switches pass through a two-flop synchronizer, and the register reports their synchronized state.

Top module: `flash_boot_guard`

## Requirements
- R1: After reset the register reads 0x01 when both switches are off. The register fields are: bit 0 is the software protect bit (reset 1), bit 1 is the map override bit (reset 0), bit 2 is the synchronized hardware protect switch, bit 3 is the synchronized boot-select switch, and bits 7:4 read 0. With csr_sel_i low, csr_rdata_o reads 0.
- R2: While the synchronized hardware protect switch is on, flash_we_o stays low for every write, whatever the software protect bit holds.
- R3: While the hardware switch is off, the software protect bit alone decides protection. Writes reach flash_we_o only after bit 0 has been cleared, and setting bit 0 again blocks them.
- R4: Bits 2 and 3 are read-only. A register write has no effect on them.
- R5: With the boot-select switch on and the override bit clear, an address whose bits 26:21 are all ones leaves with bit 20 inverted.
- R6: With the boot-select switch off, flash_addr_o equals host_addr_i.
- R7: With the override bit set, flash_addr_o equals host_addr_i even while the boot-select switch is on.
- R8: An address whose bits 26:21 are not all ones is never altered.
- R9: host_ack_o rises in the cycle after every request, including a blocked write. flash_oe_o is high only for a read request.
- R10: A change on a switch input appears in the register after exactly two clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wp_sw_i | input | 1 | Hardware write-protect switch, asynchronous |
| boot_sel_sw_i | input | 1 | Boot image select switch, asynchronous |
| csr_sel_i | input | 1 | Register access select |
| csr_wr_i | input | 1 | Register write when selected |
| csr_wdata_i | input | 8 | Register write data |
| csr_rdata_o | output | 8 | Register read data |
| host_req_i | input | 1 | Flash access request, one cycle |
| host_wr_i | input | 1 | Request is a write |
| host_addr_i | input | 27 | Host byte address |
| flash_addr_o | output | 27 | Translated flash address |
| flash_we_o | output | 1 | Flash write strobe, active high |
| flash_oe_o | output | 1 | Flash read strobe, active high |
| host_ack_o | output | 1 | Access complete, one cycle after request |

## Verification
The bench probes the boundary of the swap window at both edges of the top 2 MB, and a single address just below it. A design with the wrong window bounds would corrupt ordinary flash data or leave image B unreachable. It walks all four combinations of the hardware switch and the software bit. A design that ORs the protect sources incorrectly would strobe a write while the board switch is on. It checks that a blocked write still acknowledges, since a design that gates the acknowledge would hang the host. It also samples the status bits one edge and then two edges after each switch change, so a synchronizer that is short one flop is caught.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int CSR_W      = 8;
  localparam int BIT_SWP    = 0;
  localparam int BIT_OVR    = 1;
  localparam int BIT_HW     = 2;
  localparam int BIT_BSEL   = 3;
  localparam int NUM_SW     = 2;
  localparam int SW_HW_IDX  = 0;
  localparam int SW_BS_IDX  = 1;

  typedef struct packed {
    logic swp;
    logic ovr;
  } ctl_t;
endpackage

// File: rtl/fbg_sync.sv
module fbg_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q;
  logic [N-1:0] s2_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fbg_csr.sv
module fbg_csr
  import fbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             hw_s_i,
  input  logic             bs_s_i,
  output logic [CSR_W-1:0] rdata_o,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;
  ctl_t ctl_d;
  logic ctl_en;
  logic [CSR_W-1:0] view;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[CSR_W-1:2];
  assign ctl_en = sel_i & wr_i;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_en) begin
      ctl_d.swp = wdata_i[BIT_SWP];
      ctl_d.ovr = wdata_i[BIT_OVR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.swp <= 1'b1;
      ctl_q.ovr <= 1'b0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    view           = '0;
    view[BIT_SWP]  = ctl_q.swp;
    view[BIT_OVR]  = ctl_q.ovr;
    view[BIT_HW]   = hw_s_i;
    view[BIT_BSEL] = bs_s_i;
  end

  assign rdata_o = sel_i ? view : '0;
  assign ctl_o   = ctl_q;
endmodule

// File: rtl/fbg_remap.sv
module fbg_remap #(
  parameter int ADDR_W     = 27,
  parameter int REGION_LSB = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              swap_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WIN_LSB = REGION_LSB + 1;

  logic in_window;

  assign in_window = &addr_i[ADDR_W-1:WIN_LSB];

  always_comb begin
    addr_o = addr_i;
    if (in_window && swap_i) begin
      addr_o[REGION_LSB] = ~addr_i[REGION_LSB];
    end
  end
endmodule

// File: rtl/fbg_wgate.sv
module fbg_wgate (
  input  logic req_i,
  input  logic wr_i,
  input  logic hw_s_i,
  input  logic swp_i,
  output logic we_o,
  output logic oe_o
);
  logic locked;

  assign locked = hw_s_i | swp_i;
  assign we_o   = req_i & wr_i & ~locked;
  assign oe_o   = req_i & ~wr_i;
endmodule

// File: rtl/flash_boot_guard.sv
module flash_boot_guard
  import fbg_pkg::*;
#(
  parameter int ADDR_W     = 27,
  parameter int REGION_LSB = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_wp_sw_i,
  input  logic              boot_sel_sw_i,
  input  logic              csr_sel_i,
  input  logic              csr_wr_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  input  logic              host_req_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_we_o,
  output logic              flash_oe_o,
  output logic              host_ack_o
);
  logic rst_s1_q;
  logic rst_s2_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  logic [NUM_SW-1:0] sw_raw;
  logic [NUM_SW-1:0] sw_s;
  logic hw_s;
  logic bs_s;
  ctl_t ctl;
  logic swap_en;
  logic ack_d;
  logic ack_q;

  assign sw_raw[SW_HW_IDX] = hw_wp_sw_i;
  assign sw_raw[SW_BS_IDX] = boot_sel_sw_i;

  fbg_sync #(.N(NUM_SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (sw_raw),
    .q_o   (sw_s)
  );

  assign hw_s = sw_s[SW_HW_IDX];
  assign bs_s = sw_s[SW_BS_IDX];

  fbg_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_i   (csr_sel_i),
    .wr_i    (csr_wr_i),
    .wdata_i (csr_wdata_i),
    .hw_s_i  (hw_s),
    .bs_s_i  (bs_s),
    .rdata_o (csr_rdata_o),
    .ctl_o   (ctl)
  );

  assign swap_en = bs_s & ~ctl.ovr;

  fbg_remap #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) u_remap (
    .addr_i (host_addr_i),
    .swap_i (swap_en),
    .addr_o (flash_addr_o)
  );

  fbg_wgate u_wgate (
    .req_i  (host_req_i),
    .wr_i   (host_wr_i),
    .hw_s_i (hw_s),
    .swp_i  (ctl.swp),
    .we_o   (flash_we_o),
    .oe_o   (flash_oe_o)
  );

  assign ack_d = host_req_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ack_q <= 1'b0;
    else            ack_q <= ack_d;
  end

  assign host_ack_o = ack_q;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int ADDR_W     = 27,
  parameter int REGION_LSB = 20
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              hw_s,
  input logic              bs_s,
  input logic              swp,
  input logic              ovr,
  input logic              host_req_i,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic              flash_we_o,
  input logic              host_ack_o
);
  localparam int WIN_LSB = REGION_LSB + 1;

  a_r2_hw_blocks_we: assert property (@(posedge clk) disable iff (!rst_int_n)
    hw_s |-> !flash_we_o);

  a_r3_swp_blocks_we: assert property (@(posedge clk) disable iff (!rst_int_n)
    swp |-> !flash_we_o);

  a_r3_unlocked_write_passes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!hw_s && !swp && host_req_i && host_wr_i) |-> flash_we_o);

  a_r6_no_switch_passthru: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bs_s |-> (flash_addr_o == host_addr_i));

  a_r7_override_passthru: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovr |-> (flash_addr_o == host_addr_i));

  a_r8_outside_untouched: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(&host_addr_i[ADDR_W-1:WIN_LSB]) |-> (flash_addr_o == host_addr_i));

  a_r9_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_req_i |=> host_ack_o);
endmodule

bind flash_boot_guard fbg_checker #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .hw_s         (hw_s),
  .bs_s         (bs_s),
  .swp          (ctl.swp),
  .ovr          (ctl.ovr),
  .host_req_i   (host_req_i),
  .host_wr_i    (host_wr_i),
  .host_addr_i  (host_addr_i),
  .flash_addr_o (flash_addr_o),
  .flash_we_o   (flash_we_o),
  .host_ack_o   (host_ack_o)
);

// File: tb/flash_boot_guard_test.sv
module flash_boot_guard_test;
  localparam int AW = 27;

  logic clk;
  logic rst_n;
  logic hw_sw, bs_sw;
  logic csr_sel, csr_wr;
  logic [7:0] csr_wdata, csr_rdata;
  logic host_req, host_wr;
  logic [AW-1:0] host_addr, flash_addr;
  logic flash_we, flash_oe, host_ack;

  flash_boot_guard uut (
    .clk(clk), .rst_n(rst_n),
    .hw_wp_sw_i(hw_sw), .boot_sel_sw_i(bs_sw),
    .csr_sel_i(csr_sel), .csr_wr_i(csr_wr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .host_req_i(host_req), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .flash_addr_o(flash_addr), .flash_we_o(flash_we), .flash_oe_o(flash_oe),
    .host_ack_o(host_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [AW-1:0] addr;
    logic          we;
    logic          oe;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  logic m_swp, m_ovr, m_hw, m_bs;

  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    if (a[26:21] == 6'h3f && m_bs && !m_ovr) r[20] = ~a[20];
    return r;
  endfunction

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one request cycle; expected item goes to the scoreboard
  task automatic access(string tag, logic wr, logic [AW-1:0] a);
    exp_t e;
    @(negedge clk);
    host_req  = 1'b1;
    host_wr   = wr;
    host_addr = a;
    e.addr = model_addr(a);
    e.we   = wr && !(m_hw || m_swp);
    e.oe   = !wr;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    host_req = 1'b0;
    host_wr  = 1'b0;
  endtask

  // monitor: combinational outputs still reflect the request, ack is registered
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      #2;
      e = sb.pop_front();
      n_checks++;
      if (flash_addr !== e.addr || flash_we !== e.we || flash_oe !== e.oe || host_ack !== 1'b1) begin
        n_fail++;
        $display("FAIL %s: actual addr=%h we=%b oe=%b ack=%b expected addr=%h we=%b oe=%b ack=1",
                 e.tag, flash_addr, flash_we, flash_oe, host_ack, e.addr, e.we, e.oe);
      end
    end
  end

  task automatic csr_write(logic [7:0] d);
    @(negedge clk);
    csr_sel = 1'b1; csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_sel = 1'b0; csr_wr = 1'b0;
    m_swp = d[0];
    m_ovr = d[1];
  endtask

  function automatic logic [7:0] model_csr();
    return {4'b0, m_bs, m_hw, m_ovr, m_swp};
  endfunction

  task automatic csr_read(string tag);
    @(negedge clk);
    csr_sel = 1'b1; csr_wr = 1'b0;
    #1 chk8(tag, csr_rdata, model_csr());
    csr_sel = 1'b0;
  endtask

  task automatic set_switches(logic hw, logic bs);
    logic [7:0] old_v;
    @(negedge clk);
    old_v = model_csr();
    hw_sw = hw; bs_sw = bs;
    @(negedge clk);
    csr_sel = 1'b1;
    #1 chk8("R10 one edge", csr_rdata, old_v);
    @(negedge clk);
    m_hw = hw; m_bs = bs;
    #1 chk8("R10 two edges", csr_rdata, model_csr());
    csr_sel = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; hw_sw = 0; bs_sw = 0;
    csr_sel = 0; csr_wr = 0; csr_wdata = 0;
    host_req = 0; host_wr = 0; host_addr = '0;
    m_swp = 1; m_ovr = 0; m_hw = 0; m_bs = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1
    #1 chk8("R1 rdata unselected", csr_rdata, 8'h00);
    csr_read("R1 reset value");

    // R3 and R9: protected by software bit after reset
    access("R3 swp blocks write", 1'b1, 27'h0001000);
    access("R9 read strobe", 1'b0, 27'h0001004);
    csr_write(8'h00);
    csr_read("R3 swp cleared");
    access("R3 write passes", 1'b1, 27'h0001000);
    csr_write(8'h01);
    access("R3 swp set again", 1'b1, 27'h0002000);

    // R2: hardware switch overrides cleared swp
    csr_write(8'h00);
    set_switches(1'b1, 1'b0);
    access("R2 hw blocks write", 1'b1, 27'h0003000);
    csr_write(8'h01);
    access("R2 hw and swp", 1'b1, 27'h0003000);

    // R4: write to read-only bits ignored
    csr_write(8'hf8);
    csr_read("R4 status bits read-only");
    set_switches(1'b0, 1'b0);
    csr_write(8'h0c);
    csr_read("R4 ro bits after write of ones");

    // R6: no swap with switch off
    access("R6 top A no swap", 1'b0, 27'h7F00010);
    access("R6 top B no swap", 1'b0, 27'h7E00010);

    // R5: swap enabled
    set_switches(1'b0, 1'b1);
    access("R5 A to B", 1'b0, 27'h7FFFFFC);
    access("R5 B to A", 1'b0, 27'h7E00000);
    access("R5 window low edge", 1'b1, 27'h7E00000);

    // R8: outside window unchanged
    access("R8 just below window", 1'b0, 27'h7DFFFFC);
    access("R8 bit20 set outside", 1'b0, 27'h3F00000);
    access("R8 zero", 1'b0, 27'h0000000);

    // R7: override restores normal map
    csr_write(8'h02);
    csr_read("R7 ovr readback");
    access("R7 override A", 1'b0, 27'h7F00000);
    access("R7 override B", 1'b1, 27'h7E00040);
    csr_write(8'h00);
    access("R7 override cleared swaps", 1'b0, 27'h7F00000);

    // R9: blocked write still acknowledged, back-to-back
    set_switches(1'b1, 1'b1);
    access("R9 blocked write ack", 1'b1, 27'h7F12340);
    access("R9 second blocked write", 1'b1, 27'h0012340);

    repeat (4) @(negedge clk);
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9: actual %0d pending items expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule